// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a slow clock against the fast reference clock it runs on. It counts how many fast cycles pass while a programmed number of slow clock periods elapse, and presents that count as a result value. One of three slow sources is chosen for measurement: the currently muxed slow clock, a 32 kHz crystal clock, or an RC clock divided by 256. Each slow input passes through a two-flop synchronizer in the fast domain, and the block detects rising edges on the synchronized signal.

Software programs a small configuration register with a source select, a cycle limit, a continuous-measurement enable and a launch bit, all written together. A single measurement starts when the launch bit goes from 0 to 1. When it finishes, a ready flag rises and the result can be read. In continuous mode, which is on after reset, back-to-back windows refresh the result without using the ready flag. A cycle limit of zero gives a way to wait for the next slow edge: ready rises at the first synchronized slow rising edge after the launch.

Top module: `slowcal_top`

## Requirements
- R1: After reset the ready flag is 0, the result is 0, the launch bit is 0, the select is 0, the cycle limit is 1 and continuous mode is enabled.
- R2: For a single measurement with limit N ≥ 1, the result equals the number of fast cycles between the first synchronized slow rising edge after launch and the Nth rising edge that follows it. That is N times the slow period in fast cycles.
- R3: The select field encodes 0 as the muxed slow clock (slow_src_i bit 0), 1 as the 32 kHz crystal clock (bit 1) and 2 as the RC/256 clock (bit 2). The value 3 also selects bit 0.
- R4: A measurement launches only when a write takes the launch bit from 0 to 1. Writing 1 while the bit is already 1 has no effect on the ready flag or the result.
- R5: The ready flag is 0 in the cycle after a launch. It rises only in the cycle after a slow edge that completes a single measurement, and it stays high until it is cleared.
- R6: A pulse on rdy_clr_i clears the ready flag in the next cycle, unless a measurement completes in that same cycle.
- R7: With limit 0, a single measurement sets ready on the first synchronized slow rising edge after launch and writes a result of 0.
- R8: With continuous mode enabled and no single measurement running, windows of N slow periods run back to back. The closing edge of one window opens the next. The result is refreshed at the end of each window, and the ready flag is left unchanged.
- R9: The fast-cycle counter saturates at its all-ones value instead of wrapping, so a window longer than its range reports all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write strobe for the configuration fields |
| cfg_sel_i | input | 2 | Slow source select (0 muxed, 1 crystal 32 kHz, 2 RC/256, 3 muxed) |
| cfg_limit_i | input | LIM_W (15) | Number of slow periods per window |
| cfg_cycling_i | input | 1 | Continuous measurement enable |
| cfg_start_i | input | 1 | Launch bit; a 0-to-1 write starts a single measurement |
| rdy_clr_i | input | 1 | Clears the ready flag |
| slow_src_i | input | 3 | Asynchronous slow clocks: bit 0 muxed, bit 1 crystal, bit 2 RC/256 |
| ready_o | output | 1 | Single measurement complete |
| result_o | output | CNT_W (25) | Fast cycles counted over the last window |

## Verification
The assertions check the following on every cycle:
- A synchronized edge pulse lasts one cycle.
- A launch leaves ready low.
- A clear issued while idle takes effect.
- Ready only rises, and the result only changes, right after a slow edge.
- A saturated counter holds its value.

Only the bench scenarios can show the counted values themselves. These cover the N-times-period results for each select encoding, the zero-limit wait, the launch bit being ignored when it stays high, the refresh in continuous mode, and the saturated result.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_MUXED  = 2'd0,
        SRC_XTAL32 = 2'd1,
        SRC_RC256  = 2'd2
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       cycling;
        logic       start;
    } cal_cfg_t;

    // Unused select code 3 folds onto the muxed slow clock.
    function automatic src_sel_e decode_sel(input logic [1:0] code);
        src_sel_e s;
        case (code)
            2'd1:    s = SRC_XTAL32;
            2'd2:    s = SRC_RC256;
            default: s = SRC_MUXED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slowcal_sync.sv
module slowcal_sync #(
    parameter int NSRC   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] slow_i,
    output logic [NSRC-1:0] rise_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [DEPTH-1:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[DEPTH-2:0], slow_i[i]};
        end

        assign rise_o[i] = pipe[DEPTH-2] & ~pipe[DEPTH-1];

        p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/slowcal_cfg.sv
module slowcal_cfg
    import slowcal_pkg::*;
#(
    parameter int LIM_W     = 15,
    parameter int RST_LIMIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             cycling_i,
    input  logic             start_i,
    output cal_cfg_t         cfg_o,
    output logic [LIM_W-1:0] limit_o,
    output logic             start_pulse_o
);
    cal_cfg_t         cfg_q;
    logic [LIM_W-1:0] limit_q;

    assign start_pulse_o = we_i & start_i & ~cfg_q.start;
    assign cfg_o         = cfg_q;
    assign limit_o       = limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{sel: 2'd0, cycling: 1'b1, start: 1'b0};
            limit_q <= LIM_W'(RST_LIMIT);
        end else if (we_i) begin
            cfg_q   <= '{sel: sel_i, cycling: cycling_i, start: start_i};
            limit_q <= limit_i;
        end
    end

    p_start_edge_r4: assert property (@(posedge clk) disable iff (rst)
        start_pulse_o |=> cfg_q.start);

endmodule

// File: rtl/slowcal_core.sv
module slowcal_core
    import slowcal_pkg::*;
#(
    parameter int CNT_W = 25,
    parameter int LIM_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  cal_cfg_t         cfg_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             start_pulse_i,
    input  logic             rdy_clr_i,
    output logic             ready_o,
    output logic [CNT_W-1:0] result_o
);
    cal_state_e       state;
    logic             once;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] nedge;
    logic [CNT_W-1:0] cnt_inc;
    logic             keep_running;
    logic             last_edge;

    assign cnt_inc      = (cnt == '1) ? cnt : cnt + 1'b1;
    assign keep_running = once | cfg_i.cycling;
    assign last_edge    = (nedge + LIM_W'(1)) == limit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            once     <= 1'b0;
            cnt      <= '0;
            nedge    <= '0;
            ready_o  <= 1'b0;
            result_o <= '0;
        end else begin
            if (rdy_clr_i) ready_o <= 1'b0;
            if (start_pulse_i) begin
                state   <= ST_ARM;
                once    <= 1'b1;
                ready_o <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (cfg_i.cycling) begin
                            state <= ST_ARM;
                            once  <= 1'b0;
                        end
                    end
                    ST_ARM: begin
                        if (!keep_running) begin
                            state <= ST_IDLE;
                        end else if (edge_i) begin
                            if (limit_i == '0) begin
                                result_o <= '0;
                                if (once) begin
                                    ready_o <= 1'b1;
                                    state   <= ST_IDLE;
                                    once    <= 1'b0;
                                end
                            end else begin
                                cnt   <= CNT_W'(1);
                                nedge <= '0;
                                state <= ST_COUNT;
                            end
                        end
                    end
                    ST_COUNT: begin
                        if (!keep_running) begin
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt_inc;
                            if (edge_i) begin
                                if (last_edge) begin
                                    result_o <= cnt;
                                    if (once) begin
                                        ready_o <= 1'b1;
                                        state   <= ST_IDLE;
                                        once    <= 1'b0;
                                    end else begin
                                        cnt   <= CNT_W'(1);
                                        nedge <= '0;
                                    end
                                end else begin
                                    nedge <= nedge + LIM_W'(1);
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
        start_pulse_i |=> !ready_o);

    p_ready_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(edge_i));

    p_rdy_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (rdy_clr_i && !start_pulse_i && state == ST_IDLE) |=> !ready_o);

    p_result_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> $past(edge_i));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && cnt == '1 && !edge_i && !start_pulse_i && keep_running)
        |=> cnt == '1);

endmodule

// File: rtl/slowcal_top.sv
module slowcal_top
    import slowcal_pkg::*;
#(
    parameter int CNT_W     = 25,
    parameter int LIM_W     = 15,
    parameter int SYNC_STG  = 2,
    parameter int RST_LIMIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic [LIM_W-1:0] cfg_limit_i,
    input  logic             cfg_cycling_i,
    input  logic             cfg_start_i,
    input  logic             rdy_clr_i,
    input  logic [2:0]       slow_src_i,
    output logic             ready_o,
    output logic [CNT_W-1:0] result_o
);
    logic [NSRC-1:0]  rise;
    logic             edge_sel;
    cal_cfg_t         cfg;
    logic [LIM_W-1:0] limit;
    logic             start_pulse;

    slowcal_sync #(.NSRC(NSRC), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .slow_i (slow_src_i),
        .rise_o (rise)
    );

    slowcal_cfg #(.LIM_W(LIM_W), .RST_LIMIT(RST_LIMIT)) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .we_i          (cfg_we_i),
        .sel_i         (cfg_sel_i),
        .limit_i       (cfg_limit_i),
        .cycling_i     (cfg_cycling_i),
        .start_i       (cfg_start_i),
        .cfg_o         (cfg),
        .limit_o       (limit),
        .start_pulse_o (start_pulse)
    );

    always_comb begin
        case (decode_sel(cfg.sel))
            SRC_XTAL32: edge_sel = rise[1];
            SRC_RC256:  edge_sel = rise[2];
            default:    edge_sel = rise[0];
        endcase
    end

    slowcal_core #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .edge_i        (edge_sel),
        .cfg_i         (cfg),
        .limit_i       (limit),
        .start_pulse_i (start_pulse),
        .rdy_clr_i     (rdy_clr_i),
        .ready_o       (ready_o),
        .result_o      (result_o)
    );

endmodule

// File: tb/tb_slowcal_top.sv
module tb_slowcal_top;
    localparam int CNT_W = 25;
    localparam int LIM_W = 15;
    localparam int SAT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [LIM_W-1:0] cfg_limit = '0;
    logic             cfg_cyc = 1'b0;
    logic             cfg_start = 1'b0;
    logic             rdy_clr = 1'b0;
    logic [2:0]       slow = '0;
    logic             ready;
    logic [CNT_W-1:0] result;
    logic             ready_s;
    logic [SAT_W-1:0] result_s;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    logic ready_prev = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    slowcal_top dut (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_limit_i(cfg_limit), .cfg_cycling_i(cfg_cyc), .cfg_start_i(cfg_start),
        .rdy_clr_i(rdy_clr), .slow_src_i(slow), .ready_o(ready), .result_o(result)
    );

    slowcal_top #(.CNT_W(SAT_W)) dut_sat (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_limit_i(cfg_limit), .cfg_cycling_i(cfg_cyc), .cfg_start_i(cfg_start),
        .rdy_clr_i(rdy_clr), .slow_src_i(slow), .ready_o(ready_s), .result_o(result_s)
    );

    // Slow clocks with exact periods of 6, 10 and 14 fast cycles.
    int hc0 = 0, hc1 = 0, hc2 = 0;
    always @(negedge clk) begin
        hc0 = hc0 + 1; if (hc0 == 3) begin hc0 = 0; slow[0] = ~slow[0]; end
        hc1 = hc1 + 1; if (hc1 == 5) begin hc1 = 0; slow[1] = ~slow[1]; end
        hc2 = hc2 + 1; if (hc2 == 7) begin hc2 = 0; slow[2] = ~slow[2]; end
    end

    function automatic int period_of(input logic [1:0] sel);
        case (sel)
            2'd1:    return 10;
            2'd2:    return 14;
            default: return 6;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every rising edge of ready pops one expected result.
    always @(negedge clk) begin
        if (!rst && ready && !ready_prev) begin
            if (exp_q.size() == 0) check("R5 unexpected ready", 1, 0);
            else check("R2 one-off result", longint'(result), longint'(exp_q.pop_front()));
        end
        ready_prev <= ready;
    end

    task automatic cfg_write(input logic [1:0] sel, input int lim, input logic cyc, input logic st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_limit = LIM_W'(lim);
        cfg_cyc = cyc; cfg_start = st;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_once(input logic [1:0] sel, input int lim, input string req);
        int bound;
        bit seen;
        bound = (lim + 2) * period_of(sel) + 20;
        seen  = 0;
        cfg_write(sel, lim, 1'b0, 1'b0);
        exp_q.push_back(lim * period_of(sel));
        cfg_write(sel, lim, 1'b0, 1'b1);
        check({req, " R5 ready low after launch"}, ready, 0);
        for (int i = 0; i < bound; i++) begin
            @(negedge clk);
            if (ready) begin seen = 1; break; end
        end
        check({req, " ready within window bound"}, seen, 1);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        logic [CNT_W-1:0] held;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", ready, 0);
        check("R1 result after reset", result, 0);
        // R1/R8: continuous mode on by default, limit 1, muxed source
        repeat (40) @(negedge clk);
        check("R1 default cycling result", result, 6);
        check("R8 ready untouched by cycling", ready, 0);

        // R2, R3: single measurements on each source
        run_once(2'd0, 3, "R2 sel0");
        run_once(2'd1, 4, "R3 sel1");
        run_once(2'd2, 5, "R3 sel2");
        run_once(2'd3, 2, "R3 sel3 folds to muxed");

        // R4: start written 1 again while already 1 does nothing
        held = result;
        cfg_write(2'd1, 7, 1'b0, 1'b1);
        repeat (120) @(negedge clk);
        check("R4 ready held with start kept high", ready, 1);
        check("R4 result unchanged", result, held);

        // R6: direct clear
        @(negedge clk); rdy_clr = 1'b1;
        @(negedge clk); rdy_clr = 1'b0;
        check("R6 ready cleared", ready, 0);

        // R7: zero limit waits for next slow edge
        run_once(2'd1, 0, "R7 zero limit");
        check("R7 zero result", result, 0);

        // R8: continuous windows, ready left high
        cfg_write(2'd2, 2, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        check("R8 cycling sel2 limit2", result, 28);
        check("R8 ready unchanged in cycling", ready, 1);
        cfg_write(2'd1, 3, 1'b1, 1'b0);
        repeat (120) @(negedge clk);
        check("R8 cycling sel1 limit3", result, 30);
        repeat (37) @(negedge clk);
        check("R8 refreshed value stable", result, 30);
        cfg_write(2'd1, 3, 1'b0, 1'b0);

        // R9: saturation on the narrow-counter instance
        run_once(2'd1, 50, "R9 long window");
        check("R9 saturated result", result_s, 255);

        repeat (5) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule